// File: doc/BRIEF.md
# Reorder-Buffer Source Operand Lookup

This block resolves one source operand at dispatch time in an out-of-order core that retires in order through a circular reorder buffer. It compares the requested architectural register against the destination field of every occupied buffer slot. Among the slots that will write that register, it picks the most recently dispatched one. If that producer has already produced its result, the buffered value is forwarded. If it has not, the producer's slot number is handed on as a tag, so that the consumer can wait for it. When no slot in flight writes the register, the value read from the register file is passed through.

The buffer state arrives as flat vectors: per-slot valid, write-enable, completed, destination and result, plus the retire (read) and allocate (write) pointers. The occupied slots form a ring window. The slots from the read pointer up to the top of the array hold the older instructions. Once the window has wrapped, the slots from index 0 up to the write pointer hold the younger ones, so a match there wins. The result bus of the current cycle is also examined. A producer that is broadcasting its value right now is treated as ready. The answer is registered, so it appears one clock after the request. A core with two source operands uses two copies of this block.

Top module: `rob_src_lookup`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `out_valid`, `out_ready`, `out_tag` and `out_value` are all zero.
- R2: A slot is a producer only if it lies inside the occupied window [rd_ptr, rd_ptr+count) mod DEPTH and has its valid bit set, its write bit set and its destination equal to `src_reg`. Slots outside the window, slots with the write bit clear, invalid slots and slots with a different destination are ignored.
- R3: When the window has not wrapped (wr_ptr > rd_ptr), the producer with the highest slot index is selected.
- R4: When the window has wrapped (wr_ptr < rd_ptr), any producer in slots 0..wr_ptr-1 beats every producer in slots rd_ptr..DEPTH-1. Within a region, the highest index wins.
- R5: When wr_ptr equals rd_ptr and the slot at rd_ptr is valid, the buffer is full and all DEPTH slots are in the window. The youngest slot is then rd_ptr-1 (mod DEPTH).
- R6: If the selected producer is completed, the result is ready=1, tag=slot index and value=that slot's result.
- R7: If the selected producer is not completed and is not on the result bus, the result is ready=0, tag=slot index and value=0.
- R8: If the selected producer is not completed but `cdb_valid` is high with `cdb_tag` equal to its index, the result is ready=1, tag=slot index and value=`cdb_data`. A broadcast with any other tag has no effect.
- R9: With no producer, the result is ready=1, tag=0 and value=`rf_data`.
- R10: A `src_reg` of 0 always gives ready=1, tag=0 and value=0, whatever the buffer holds.
- R11: Each output reflects the inputs sampled at the previous rising clock edge. `out_valid` equals the previous `lookup_valid`, and when it is 0 the other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | A lookup is requested this cycle |
| src_reg | input | REG_W | Architectural source register |
| rf_data | input | XLEN | Register-file read data for `src_reg` |
| rd_ptr | input | TAG_W | Retire pointer (oldest slot) |
| wr_ptr | input | TAG_W | Allocate pointer (next free slot) |
| ent_valid | input | DEPTH | Per-slot valid |
| ent_wr | input | DEPTH | Per-slot register-write flag |
| ent_done | input | DEPTH | Per-slot result-completed flag |
| ent_dest | input | DEPTH*REG_W | Per-slot destination register, slot i at bits [i*REG_W +: REG_W] |
| ent_data | input | DEPTH*XLEN | Per-slot buffered result, slot i at bits [i*XLEN +: XLEN] |
| cdb_valid | input | 1 | Result bus carries a value this cycle |
| cdb_tag | input | TAG_W | Slot index of the broadcasting producer |
| cdb_data | input | XLEN | Broadcast value |
| out_valid | output | 1 | Registered: lookup result present |
| out_ready | output | 1 | Registered: operand value is available |
| out_tag | output | TAG_W | Registered: producer slot index, or 0 |
| out_value | output | XLEN | Registered: operand value, or 0 when waiting |

## Verification
Every result is due exactly one rising edge after the request: the match, priority and bypass logic are combinational and feed one output register. The bench therefore drives a request just after a falling edge and computes the expected answer at once from a behavioural model. That model walks the occupied window in age order from the read pointer. It compares at the next falling edge, when the register has taken the value and no input is changing. The reset values are sampled at a falling edge while reset is held.

// File: rtl/rob_lkp_pkg.sv
package rob_lkp_pkg;

    // How the operand of the current request is resolved.
    typedef enum logic [2:0] {
        SRC_IDLE,       // no request
        SRC_ZERO,       // hard-wired zero register
        SRC_REGFILE,    // no producer in flight
        SRC_ROB_DONE,   // producer finished, value buffered
        SRC_ROB_BYPASS, // producer broadcasting this cycle
        SRC_ROB_WAIT    // producer still executing
    } src_kind_e;

endpackage

// File: rtl/rob_lkp_match.sv
// Per-slot producer detection, split into the two age regions of the ring.
module rob_lkp_match #(
    parameter int DEPTH = 32,
    parameter int REG_W = 5,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [REG_W-1:0]       src_reg,
    input  logic [TAG_W-1:0]       rd_ptr,
    input  logic [TAG_W-1:0]       wr_ptr,
    input  logic [DEPTH-1:0]       ent_valid,
    input  logic [DEPTH-1:0]       ent_wr,
    input  logic [DEPTH*REG_W-1:0] ent_dest,
    output logic [DEPTH-1:0]       hit_young,
    output logic [DEPTH-1:0]       hit_old
);

    logic full;
    logic wrapped;

    // Equal pointers with an occupied head slot means every slot is live.
    assign full    = (wr_ptr == rd_ptr) && ent_valid[rd_ptr];
    assign wrapped = (wr_ptr < rd_ptr) || full;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic writes_src;
        logic in_old;
        logic in_young;

        assign writes_src = ent_valid[i] && ent_wr[i] &&
                            (ent_dest[i*REG_W +: REG_W] == src_reg);
        // Older region: from the retire pointer to the top of the array.
        assign in_old     = (TAG_W'(i) >= rd_ptr) &&
                            (wrapped || (TAG_W'(i) < wr_ptr));
        // Younger region: from slot 0 to the allocate pointer, wrapped only.
        assign in_young   = wrapped && (TAG_W'(i) < wr_ptr);

        assign hit_old[i]   = writes_src && in_old;
        assign hit_young[i] = writes_src && in_young;
    end

endmodule

// File: rtl/rob_lkp_prio.sv
// Highest-index picker for one region.
module rob_lkp_prio #(
    parameter int DEPTH = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    output logic             any,
    output logic [TAG_W-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = TAG_W'(i);
            end
        end
    end

endmodule

// File: rtl/rob_src_lookup.sv
module rob_src_lookup
    import rob_lkp_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int REG_W = 5,
    parameter int XLEN  = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lookup_valid,
    input  logic [REG_W-1:0]       src_reg,
    input  logic [XLEN-1:0]        rf_data,
    input  logic [TAG_W-1:0]       rd_ptr,
    input  logic [TAG_W-1:0]       wr_ptr,
    input  logic [DEPTH-1:0]       ent_valid,
    input  logic [DEPTH-1:0]       ent_wr,
    input  logic [DEPTH-1:0]       ent_done,
    input  logic [DEPTH*REG_W-1:0] ent_dest,
    input  logic [DEPTH*XLEN-1:0]  ent_data,
    input  logic                   cdb_valid,
    input  logic [TAG_W-1:0]       cdb_tag,
    input  logic [XLEN-1:0]        cdb_data,
    output logic                   out_valid,
    output logic                   out_ready,
    output logic [TAG_W-1:0]       out_tag,
    output logic [XLEN-1:0]        out_value
);

    localparam int NREGION = 2;   // 0 = younger (wrapped part), 1 = older

    logic [NREGION-1:0][DEPTH-1:0] region_req;
    logic [NREGION-1:0]            region_any;
    logic [NREGION-1:0][TAG_W-1:0] region_idx;

    logic             hit_any;
    logic [TAG_W-1:0] sel_idx;
    src_kind_e        kind;

    logic             nxt_valid;
    logic             nxt_ready;
    logic [TAG_W-1:0] nxt_tag;
    logic [XLEN-1:0]  nxt_value;

    rob_lkp_match #(.DEPTH(DEPTH), .REG_W(REG_W)) u_match (
        .src_reg   (src_reg),
        .rd_ptr    (rd_ptr),
        .wr_ptr    (wr_ptr),
        .ent_valid (ent_valid),
        .ent_wr    (ent_wr),
        .ent_dest  (ent_dest),
        .hit_young (region_req[0]),
        .hit_old   (region_req[1])
    );

    for (genvar g = 0; g < NREGION; g++) begin : g_region
        rob_lkp_prio #(.DEPTH(DEPTH)) u_pick (
            .req (region_req[g]),
            .any (region_any[g]),
            .idx (region_idx[g])
        );
    end

    // The younger region wins whenever it holds a producer.
    assign hit_any = |region_any;
    assign sel_idx = region_any[0] ? region_idx[0] : region_idx[1];

    // Classify the request.
    always_comb begin
        if (!lookup_valid) begin
            kind = SRC_IDLE;
        end else if (src_reg == '0) begin
            kind = SRC_ZERO;
        end else if (!hit_any) begin
            kind = SRC_REGFILE;
        end else if (ent_done[sel_idx]) begin
            kind = SRC_ROB_DONE;
        end else if (cdb_valid && (cdb_tag == sel_idx)) begin
            kind = SRC_ROB_BYPASS;
        end else begin
            kind = SRC_ROB_WAIT;
        end
    end

    // Form the result for each kind.
    always_comb begin
        nxt_valid = 1'b1;
        nxt_ready = 1'b1;
        nxt_tag   = '0;
        nxt_value = '0;
        unique case (kind)
            SRC_IDLE: begin
                nxt_valid = 1'b0;
                nxt_ready = 1'b0;
            end
            SRC_ZERO: begin
            end
            SRC_REGFILE: begin
                nxt_value = rf_data;
            end
            SRC_ROB_DONE: begin
                nxt_tag   = sel_idx;
                nxt_value = ent_data[sel_idx*XLEN +: XLEN];
            end
            SRC_ROB_BYPASS: begin
                nxt_tag   = sel_idx;
                nxt_value = cdb_data;
            end
            SRC_ROB_WAIT: begin
                nxt_ready = 1'b0;
                nxt_tag   = sel_idx;
            end
            default: begin
                nxt_valid = 1'b0;
                nxt_ready = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ready <= 1'b0;
            out_tag   <= '0;
            out_value <= '0;
        end else begin
            out_valid <= nxt_valid;
            out_ready <= nxt_ready;
            out_tag   <= nxt_tag;
            out_value <= nxt_value;
        end
    end

endmodule

// File: rtl/rob_src_lookup_chk.sv
module rob_src_lookup_chk #(
    parameter int DEPTH = 32,
    parameter int REG_W = 5,
    parameter int XLEN  = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lookup_valid,
    input logic [REG_W-1:0] src_reg,
    input logic [XLEN-1:0]  rf_data,
    input logic [DEPTH-1:0] ent_valid,
    input logic [DEPTH-1:0] ent_done,
    input logic             out_valid,
    input logic             out_ready,
    input logic [TAG_W-1:0] out_tag,
    input logic [XLEN-1:0]  out_value
);

    logic [DEPTH-1:0] prev_valid;
    logic [DEPTH-1:0] prev_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= '0;
            prev_done  <= '0;
        end else begin
            prev_valid <= ent_valid;
            prev_done  <= ent_done;
        end
    end

    a_r11_follow: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> out_valid);

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_ready && out_tag == '0 && out_value == '0));

    a_r10_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && src_reg == '0) |=>
            (out_ready && out_tag == '0 && out_value == '0));

    a_r9_empty_rf: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && src_reg != '0 && ent_valid == '0) |=>
            (out_ready && out_tag == '0 && out_value == $past(rf_data)));

    a_r7_wait_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |->
            (out_value == '0 && prev_valid[out_tag] && !prev_done[out_tag]));

endmodule

bind rob_src_lookup rob_src_lookup_chk #(
    .DEPTH (DEPTH),
    .REG_W (REG_W),
    .XLEN  (XLEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .src_reg      (src_reg),
    .rf_data      (rf_data),
    .ent_valid    (ent_valid),
    .ent_done     (ent_done),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_tag      (out_tag),
    .out_value    (out_value)
);

// File: tb/tb_rob_src_lookup.sv
module tb_rob_src_lookup;

    localparam int DEPTH = 32;
    localparam int REG_W = 5;
    localparam int XLEN  = 32;
    localparam int TAG_W = $clog2(DEPTH);
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM = 3000;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   lookup_valid;
    logic [REG_W-1:0]       src_reg;
    logic [XLEN-1:0]        rf_data;
    logic [TAG_W-1:0]       rd_ptr;
    logic [TAG_W-1:0]       wr_ptr;
    logic [DEPTH-1:0]       ent_valid;
    logic [DEPTH-1:0]       ent_wr;
    logic [DEPTH-1:0]       ent_done;
    logic [DEPTH*REG_W-1:0] ent_dest;
    logic [DEPTH*XLEN-1:0]  ent_data;
    logic                   cdb_valid;
    logic [TAG_W-1:0]       cdb_tag;
    logic [XLEN-1:0]        cdb_data;
    logic                   out_valid;
    logic                   out_ready;
    logic [TAG_W-1:0]       out_tag;
    logic [XLEN-1:0]        out_value;

    logic [REG_W-1:0] e_dest [DEPTH];
    logic [XLEN-1:0]  e_data [DEPTH];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_dest[i*REG_W +: REG_W] = e_dest[i];
            ent_data[i*XLEN +: XLEN]   = e_data[i];
        end
    end

    rob_src_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid),
        .src_reg(src_reg), .rf_data(rf_data), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
        .ent_valid(ent_valid), .ent_wr(ent_wr), .ent_done(ent_done),
        .ent_dest(ent_dest), .ent_data(ent_data), .cdb_valid(cdb_valid),
        .cdb_tag(cdb_tag), .cdb_data(cdb_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_tag(out_tag), .out_value(out_value)
    );

    // Behavioural reference: walk the occupied window oldest to youngest.
    task automatic model(output logic v, output logic r,
                         output logic [TAG_W-1:0] t, output logic [XLEN-1:0] d,
                         output string lbl);
        int cnt;
        int last;
        bit full;
        v = 0; r = 0; t = '0; d = '0; lbl = "R11";
        if (!lookup_valid) return;
        v = 1;
        if (src_reg == 0) begin
            r = 1; lbl = "R10"; return;
        end
        full = (wr_ptr == rd_ptr) && ent_valid[rd_ptr];
        cnt  = full ? DEPTH : ((int'(wr_ptr) - int'(rd_ptr) + DEPTH) % DEPTH);
        last = -1;
        for (int k = 0; k < cnt; k++) begin
            int idx;
            idx = (int'(rd_ptr) + k) % DEPTH;
            if (ent_valid[idx] && ent_wr[idx] && e_dest[idx] == src_reg) last = idx;
        end
        if (last < 0) begin
            r = 1; d = rf_data; lbl = "R9"; return;
        end
        t = TAG_W'(last);
        lbl = full ? "R5" : ((wr_ptr < rd_ptr) ? "R4" : "R3");
        if (ent_done[last]) begin
            r = 1; d = e_data[last]; lbl = {lbl, " R6"};
        end else if (cdb_valid && cdb_tag == TAG_W'(last)) begin
            r = 1; d = cdb_data; lbl = {lbl, " R8"};
        end else begin
            lbl = {lbl, " R7"};
        end
    endtask

    // One request: model now, compare at the next falling edge.
    task automatic step(input string tag);
        logic ev, er;
        logic [TAG_W-1:0] et;
        logic [XLEN-1:0] ed;
        string lbl;
        model(ev, er, et, ed, lbl);
        if (tag != "") lbl = tag;
        @(negedge clk);
        n_checks++;
        if (out_valid !== ev || out_ready !== er || out_tag !== et || out_value !== ed) begin
            n_fails++;
            $display("FAIL %s: actual v=%0b r=%0b tag=%0d val=%h expected v=%0b r=%0b tag=%0d val=%h",
                     lbl, out_valid, out_ready, out_tag, out_value, ev, er, et, ed);
        end
    endtask

    task automatic clear_rob();
        ent_valid = '0; ent_wr = '0; ent_done = '0;
        for (int i = 0; i < DEPTH; i++) begin
            e_dest[i] = '0;
            e_data[i] = 32'hDEAD_0000 + i;
        end
        rd_ptr = '0; wr_ptr = '0;
        cdb_valid = 0; cdb_tag = '0; cdb_data = '0;
        lookup_valid = 1; rf_data = 32'h1234_5678;
    endtask

    task automatic put(input int idx, input int dest, input bit done);
        ent_valid[idx] = 1; ent_wr[idx] = 1; ent_done[idx] = done;
        e_dest[idx] = REG_W'(dest);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog R11: actual=hung expected=run complete");
        finish_run();
    end

    initial begin
        rst_n = 0;
        clear_rob();
        lookup_valid = 1; src_reg = 5'd3;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero under reset
        n_checks++;
        if (out_valid !== 0 || out_ready !== 0 || out_tag !== 0 || out_value !== 0) begin
            n_fails++;
            $display("FAIL R1: actual v=%0b r=%0b tag=%0d val=%h expected all zero",
                     out_valid, out_ready, out_tag, out_value);
        end
        rst_n = 1;

        // R9: empty buffer passes register file data
        clear_rob(); src_reg = 5'd5; step("R9 empty");
        // R10: zero register with zero-destination producers
        clear_rob(); wr_ptr = 5'd4; put(1, 0, 1); put(2, 0, 0); src_reg = 0; step("R10");
        // R2: write flag clear, invalid slot, other destination
        clear_rob(); wr_ptr = 5'd6; put(2, 7, 1); ent_wr[2] = 0;
        put(3, 7, 1); ent_valid[3] = 0; put(4, 8, 1); src_reg = 5'd7; step("R2 ignored slots");
        // R2: valid producer beyond the write pointer is outside the window
        clear_rob(); rd_ptr = 5'd2; wr_ptr = 5'd6; put(3, 9, 1); put(10, 9, 1);
        src_reg = 5'd9; step("R2 window");
        // R3: not wrapped, youngest of several
        clear_rob(); rd_ptr = 5'd2; wr_ptr = 5'd10; put(3, 6, 1); put(7, 6, 1); put(5, 6, 1);
        src_reg = 5'd6; step("R3 R6");
        // R4: wrapped, lower region wins over higher indices
        clear_rob(); rd_ptr = 5'd28; wr_ptr = 5'd4; put(30, 11, 1); put(1, 11, 1); put(29, 11, 0);
        src_reg = 5'd11; step("R4 R6");
        // R4: wrapped, only old region matches
        clear_rob(); rd_ptr = 5'd28; wr_ptr = 5'd4; put(29, 11, 1); put(31, 11, 1); put(2, 12, 1);
        src_reg = 5'd11; step("R4 old region");
        // R5: full buffer, youngest is rd_ptr-1
        clear_rob(); rd_ptr = 5'd12; wr_ptr = 5'd12;
        for (int i = 0; i < DEPTH; i++) put(i, 20 + (i % 3), 1);
        put(20, 13, 1); put(11, 13, 1); src_reg = 5'd13; step("R5 R6");
        // R7: pending producer gives its tag
        clear_rob(); rd_ptr = 5'd0; wr_ptr = 5'd8; put(3, 4, 1); put(6, 4, 0);
        src_reg = 5'd4; step("R7");
        // R7: broadcast of another tag does not help
        cdb_valid = 1; cdb_tag = 5'd3; cdb_data = 32'hAAAA_5555; step("R7 other tag");
        // R8: broadcast for selected producer bypasses
        cdb_tag = 5'd6; step("R8");
        // R11: no request gives zero outputs
        lookup_valid = 0; step("R11 idle");

        for (int n = 0; n < N_RANDOM; n++) begin
            lookup_valid = ($urandom_range(9) != 0);
            src_reg = REG_W'($urandom_range(4));
            rf_data = $urandom;
            rd_ptr = TAG_W'($urandom);
            wr_ptr = (($urandom_range(7)) == 0) ? rd_ptr : TAG_W'($urandom);
            for (int i = 0; i < DEPTH; i++) begin
                ent_valid[i] = ($urandom_range(4) != 0);
                ent_wr[i]    = ($urandom_range(4) != 0);
                ent_done[i]  = $urandom_range(1);
                e_dest[i]    = REG_W'($urandom_range(4));
                e_data[i]    = $urandom;
            end
            cdb_valid = $urandom_range(1);
            cdb_tag   = TAG_W'($urandom);
            cdb_data  = $urandom;
            step("");
        end
        finish_run();
    end

endmodule